// File: doc/BRIEF.md
# Cycle-Counting Interrupt Timer

This block is a down-counter that is stepped once per CPU cycle and raises an active-high interrupt request when it runs out. Software programs it through three register indices: a control register, a low-byte register and a high-byte register. The counter width is twice the byte width, so the default configuration gives a 16-bit count.

A build-time mode picks one of two variants. In the direct variant, the byte writes go straight into the running counter. In the latched variant, the byte writes fill a reload latch, and every control write copies that latch into the counter. In both variants a control write sets or clears the count enable and always withdraws a pending request. Each clock of `clk` is treated as one CPU cycle. Address decoding above the register index is left to the surrounding logic.

Top module: `irq_cycle_timer`

## Requirements
- R1: After a synchronous reset, `count` is zero, `irq` is low and counting is disabled, so `count` stays at zero until software writes.
- R2: A write to index 0xB replaces the low byte of the target (the counter in direct mode, the latch in latched mode) and leaves its high byte unchanged.
- R3: A write to index 0xC replaces the high byte of the target and leaves its low byte unchanged.
- R4: In latched mode, writes to index 0xB and 0xC do not change `count`.
- R5: In latched mode, every write to index 0xA copies the whole latch into the counter in the same cycle.
- R6: A write to index 0xA stores bit 0 of the data as the count enable; while it is 1, `count` drops by one on every cycle.
- R7: While the enable is 0, `count` holds its value and `irq` keeps its level.
- R8: On an enabled cycle where `count` is zero, `irq` goes high and `count` wraps to all ones; a counter started at N therefore raises `irq` N+1 cycles after the enabling write.
- R9: Once high, `irq` stays high until the next write to index 0xA, which always clears it, whatever the written data.
- R10: When a write loads the counter in the same cycle as a count step, the written value is taken and no step or interrupt happens in that cycle.
- R11: Writes to any index other than 0xA, 0xB and 0xC change neither the counter, the latch, the enable nor `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one edge per CPU cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Register index of the write |
| wr_data | input | BYTE_W | Write data byte |
| irq | output | 1 | Interrupt request, active high |
| count | output | 2*BYTE_W | Current counter value |

## Verification
The bench builds two copies side by side, one per mode, both with a 4-bit byte so the counter is 8 bits wide. That shrinks the full count range to 256 values, which lets the direct copy be started from every possible value and its interrupt delay be checked against N+1, wrap to all ones included. The latched copy gets a stride of starting values plus the reload-on-control cases. Same-cycle collisions between a load and a step, including a load landing on a zero count, are driven on purpose.

// File: rtl/timer_pkg.sv
// Shared types for the cycle-counting interrupt timer.
package timer_pkg;

    // Which way the byte registers reach the counter.
    typedef enum logic {
        MODE_DIRECT  = 1'b0,   // byte writes load the counter
        MODE_LATCHED = 1'b1    // byte writes load a latch, control reloads
    } timer_mode_e;

endpackage

// File: rtl/timer_decode.sv
// Register index decoder.
// Turns one write strobe plus index into one-hot strobes for the control,
// low-byte and high-byte registers. Assumes at most one write per cycle.
// Any other index produces no strobe.
module timer_decode #(
    parameter int IDX_W    = 4,
    parameter int CTRL_IDX = 10,
    parameter int LO_IDX   = 11,
    parameter int HI_IDX   = 12
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    output logic             ctrl_wr,
    output logic             lo_wr,
    output logic             hi_wr
);

    // Compare the index against each register's slot.
    always_comb begin
        ctrl_wr = wr_en && (wr_idx == IDX_W'(CTRL_IDX));
        lo_wr   = wr_en && (wr_idx == IDX_W'(LO_IDX));
        hi_wr   = wr_en && (wr_idx == IDX_W'(HI_IDX));
    end

endmodule

// File: rtl/timer_reload.sv
// Enable flag and load-path selection.
// Holds the count enable and, in latched mode, the reload latch. Produces a
// load strobe plus the value the counter must take this cycle.
// Assumes ctrl_wr, lo_wr and hi_wr are mutually exclusive.
module timer_reload
    import timer_pkg::*;
#(
    parameter timer_mode_e MODE   = MODE_DIRECT,
    parameter int          BYTE_W = 8,
    localparam int         CNT_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  cur_count,
    output logic              en_q,
    output logic              load,
    output logic [CNT_W-1:0]  load_val
);

    // Count enable: bit 0 of every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (ctrl_wr) en_q <= wr_data[0];
    end

    generate
        if (MODE == MODE_LATCHED) begin : g_latched
            logic [CNT_W-1:0] latch_q;

            // Reload latch: byte writes fill one half, keep the other.
            always_ff @(posedge clk) begin
                if (!rst_n)     latch_q <= '0;
                else if (lo_wr) latch_q <= {latch_q[CNT_W-1:BYTE_W], wr_data};
                else if (hi_wr) latch_q <= {wr_data, latch_q[BYTE_W-1:0]};
            end

            // Control writes copy the latch into the counter.
            always_comb begin
                load     = ctrl_wr;
                load_val = latch_q;
            end

            AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
                ctrl_wr |=> (cur_count == $past(latch_q)))
                else $error("counter not reloaded from latch"); // R5

            AST_BYTE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
                ((lo_wr || hi_wr) && !en_q) |=> $stable(cur_count))
                else $error("byte write reached counter in latched mode"); // R4
        end else begin : g_direct
            // Byte writes merge into the live counter value.
            always_comb begin
                load     = lo_wr || hi_wr;
                load_val = lo_wr ? {cur_count[CNT_W-1:BYTE_W], wr_data}
                                 : {wr_data, cur_count[BYTE_W-1:0]};
            end

            AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
                lo_wr |=> (cur_count[CNT_W-1:BYTE_W] == $past(cur_count[CNT_W-1:BYTE_W])))
                else $error("low write disturbed high byte"); // R2

            AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
                hi_wr |=> (cur_count[BYTE_W-1:0] == $past(cur_count[BYTE_W-1:0])))
                else $error("high write disturbed low byte"); // R3
        end
    endgenerate

endmodule

// File: rtl/timer_counter.sv
// Down-counter and interrupt flag.
// Steps down once per enabled cycle; a load takes priority over the step.
// Reaching zero on a stepping cycle raises irq and wraps to all ones.
// Assumes ctrl_wr is the control register write strobe.
module timer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_q,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ctrl_wr,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    logic step;

    // A step happens only on enabled cycles without a load.
    always_comb step = en_q && !load;

    // Counter register: load wins, otherwise step down (wraps from zero).
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (step) count <= count - 1'b1;
    end

    // Interrupt flag: cleared by control writes, set on a step from zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                       irq <= 1'b0;
        else if (ctrl_wr)                 irq <= 1'b0;
        else if (step && (count == '0))   irq <= 1'b1;
    end

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !load && !$isunknown(count)) |=> (count == CNT_W'($past(count) - 1'b1)))
        else $error("counter did not step by one"); // R6

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !load) |=> $stable(count))
        else $error("counter moved while disabled"); // R7

    AST_IRQ_KEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !ctrl_wr) |=> (irq == $past(irq)))
        else $error("irq changed while disabled"); // R7

    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !load && (count == '0)) |=> (&count))
        else $error("counter did not wrap to all ones"); // R8

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(count) == '0))
        else $error("irq rose away from zero"); // R8

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ctrl_wr) |=> irq)
        else $error("irq dropped without control write"); // R9

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !irq)
        else $error("control write did not clear irq"); // R9

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)))
        else $error("load lost to a step"); // R10

endmodule

// File: rtl/irq_cycle_timer.sv
// Cycle-counting interrupt timer, top level.
// Three register indices program a down-counter stepped on every clock
// (one clock = one CPU cycle). MODE selects direct loading of the counter
// or loading through a reload latch copied on control writes.
// Assumes the index has already been qualified by upper address decode.
module irq_cycle_timer
    import timer_pkg::*;
#(
    parameter timer_mode_e MODE     = MODE_DIRECT,
    parameter int          BYTE_W   = 8,
    parameter int          IDX_W    = 4,
    parameter int          CTRL_IDX = 10,
    parameter int          LO_IDX   = 11,
    parameter int          HI_IDX   = 12,
    localparam int         CNT_W    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              irq,
    output logic [CNT_W-1:0]  count
);

    logic             ctrl_wr, lo_wr, hi_wr;
    logic             en_q, load;
    logic [CNT_W-1:0] load_val;

    timer_decode #(
        .IDX_W    (IDX_W),
        .CTRL_IDX (CTRL_IDX),
        .LO_IDX   (LO_IDX),
        .HI_IDX   (HI_IDX)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .ctrl_wr (ctrl_wr),
        .lo_wr   (lo_wr),
        .hi_wr   (hi_wr)
    );

    timer_reload #(
        .MODE   (MODE),
        .BYTE_W (BYTE_W)
    ) u_reload (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .lo_wr     (lo_wr),
        .hi_wr     (hi_wr),
        .wr_data   (wr_data),
        .cur_count (count),
        .en_q      (en_q),
        .load      (load),
        .load_val  (load_val)
    );

    timer_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_q     (en_q),
        .load     (load),
        .load_val (load_val),
        .ctrl_wr  (ctrl_wr),
        .count    (count),
        .irq      (irq)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ctrl_wr, lo_wr, hi_wr}) <= 1)
        else $error("more than one register strobe"); // R11

    AST_OTHER_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctrl_wr && !lo_wr && !hi_wr) |=> (en_q == $past(en_q)))
        else $error("unused index changed the enable"); // R11

endmodule

// File: tb/tb_irq_cycle_timer.sv
// Bench: one direct and one latched copy, both with a 4-bit byte.
module tb_irq_cycle_timer;
    import timer_pkg::*;

    localparam int BW = 4;
    localparam int CW = 2 * BW;
    localparam logic [3:0] I_CTRL = 4'hA;
    localparam logic [3:0] I_LO   = 4'hB;
    localparam logic [3:0] I_HI   = 4'hC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_d = 1'b0, en_l = 1'b0;
    logic [3:0]    idx = '0;
    logic [BW-1:0] dat = '0;
    logic          irq_d, irq_l;
    logic [CW-1:0] cnt_d, cnt_l;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    irq_cycle_timer #(.MODE(MODE_DIRECT), .BYTE_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(en_d), .wr_idx(idx), .wr_data(dat),
        .irq(irq_d), .count(cnt_d));

    irq_cycle_timer #(.MODE(MODE_LATCHED), .BYTE_W(BW)) dut_l (
        .clk(clk), .rst_n(rst_n), .wr_en(en_l), .wr_idx(idx), .wr_data(dat),
        .irq(irq_l), .count(cnt_l));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input bit lat, input logic [3:0] i, input logic [BW-1:0] d);
        idx = i; dat = d;
        if (lat) en_l = 1'b1; else en_d = 1'b1;
        @(negedge clk);
        en_l = 1'b0; en_d = 1'b0;
    endtask

    // Count edges after the enabling write until irq is seen.
    task automatic measure(input bit lat, input int n, input string req);
        int k = 0;
        bit seen = 0;
        while (!seen && k < 300) begin
            @(negedge clk);
            k++;
            if (k == 1 && n != 0)
                chk({req, "/R6 first step"}, lat ? cnt_l : cnt_d, (n - 1) & 8'hFF);
            seen = lat ? irq_l : irq_d;
        end
        chk({req, "/R8 irq delay"}, k, n + 1);
        chk({req, "/R8 wrap"}, lat ? cnt_l : cnt_d, 8'hFF);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, no counting afterwards
        chk("R1 count d", cnt_d, 0);  chk("R1 irq d", irq_d, 0);
        chk("R1 count l", cnt_l, 0);  chk("R1 irq l", irq_l, 0);
        repeat (5) @(negedge clk);
        chk("R1 idle d", cnt_d, 0);   chk("R1 idle l", cnt_l, 0);

        // R2/R3 direct byte writes
        wr(0, I_LO, 4'h5);  chk("R2 lo", cnt_d, 8'h05);
        wr(0, I_HI, 4'h3);  chk("R3 hi", cnt_d, 8'h35);
        wr(0, I_LO, 4'hA);  chk("R2 lo keeps hi", cnt_d, 8'h3A);
        wr(0, I_HI, 4'h6);  chk("R3 hi keeps lo", cnt_d, 8'h6A);

        // R4/R5 latched byte writes then reload
        wr(1, I_LO, 4'h5);  chk("R4 lo no count", cnt_l, 0);
        wr(1, I_HI, 4'h3);  chk("R4 hi no count", cnt_l, 0);
        wr(1, I_CTRL, 4'h0); chk("R5 reload", cnt_l, 8'h35);
        repeat (10) @(negedge clk);
        chk("R7 hold l", cnt_l, 8'h35);
        chk("R7 hold d", cnt_d, 8'h6A);

        // R11 unused indices
        for (int i = 0; i < 16; i++) begin
            if (i != I_CTRL && i != I_LO && i != I_HI) begin
                wr(0, 4'(i), 4'hF);
                wr(1, 4'(i), 4'hF);
            end
        end
        chk("R11 count d", cnt_d, 8'h6A);
        chk("R11 count l", cnt_l, 8'h35);
        repeat (4) @(negedge clk);
        chk("R11 enable d", cnt_d, 8'h6A);
        wr(1, I_CTRL, 4'h0); chk("R11 latch l", cnt_l, 8'h35);

        // R8 direct sweep over every start value
        for (int n = 0; n < 256; n++) begin
            wr(0, I_CTRL, 4'h0);
            wr(0, I_LO, 4'(n));
            wr(0, I_HI, 4'(n >> 4));
            wr(0, I_CTRL, 4'h1);
            measure(0, n, "direct");
        end

        // R9 irq sticks while counting on, then control write clears it
        repeat (20) @(negedge clk);
        chk("R9 sticky d", irq_d, 1);
        wr(0, I_CTRL, 4'h1);
        chk("R9 clear d", irq_d, 0);

        // R5/R8 latched sweep
        for (int n = 0; n < 256; n += 17) begin
            wr(1, I_CTRL, 4'h0);
            wr(1, I_LO, 4'(n));
            wr(1, I_HI, 4'(n >> 4));
            wr(1, I_CTRL, 4'h1);
            measure(1, n, "latched");
        end
        repeat (7) @(negedge clk);
        chk("R9 sticky l", irq_l, 1);
        wr(1, I_CTRL, 4'h1);   // last latch value was 0xFF
        chk("R9 clear l", irq_l, 0);
        chk("R5 reload on re-enable", cnt_l, 8'hFF);

        // R10 byte write collides with a step (direct)
        c = cnt_d;
        wr(0, I_LO, 4'h7);
        chk("R10 write wins", cnt_d, ((c & 8'hF0) | 8'h07));
        @(negedge clk);
        chk("R10 next step", cnt_d, ((c & 8'hF0) | 8'h06));

        // R10 load lands on a zero count: no irq
        wr(0, I_CTRL, 4'h0);
        wr(0, I_HI, 4'h0);
        wr(0, I_LO, 4'h2);
        wr(0, I_CTRL, 4'h1);
        @(negedge clk); @(negedge clk);
        chk("R10 at zero", cnt_d, 0);
        wr(0, I_LO, 4'h5);
        chk("R10 zero load", cnt_d, 8'h05);
        chk("R10 no irq", irq_d, 0);

        // R10 latched: control write while counting takes the latch
        wr(1, I_LO, 4'h9);
        wr(1, I_CTRL, 4'h1);
        chk("R10 latched reload", cnt_l, 8'hF9);

        // R7 disable holds value
        wr(0, I_CTRL, 4'h0);
        c = cnt_d;
        repeat (8) @(negedge clk);
        chk("R7 hold after disable", cnt_d, c);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule